// File: doc/BRIEF.md
# Fixed-Point Add/Subtract Unit with Condition Code

This unit adds or subtracts two binary integers and reports a 2-bit condition code of the kind a general-purpose processor's branch logic consumes. It has four operation flavours: logical (unsigned) add, logical subtract, arithmetic (two's-complement) add and arithmetic subtract. Each flavour runs at either a narrow 32-bit or a full 64-bit operand width. The sum or difference always wraps modulo 2^width.

The two families encode the condition code differently. Logical operations report two independent flags: "result is nonzero" in the low bit and "carry out / no borrow" in the high bit. Arithmetic operations report one enumerated value: zero, negative, positive or overflow. Overflow is found from the operand and result sign bits alone, without a wider intermediate.

A request is taken whenever `in_valid` is high. The result and the code appear one clock later, qualified by `out_valid`. Registered outputs keep their last value until the next request arrives.

Top module: `fxadd_unit`

## Requirements
- R1: With `in_op`=0 (add) and `in_signed`=0, `out_cc[0]` is 1 exactly when the wrapped sum is nonzero, and `out_cc[1]` is 1 exactly when the true unsigned sum is 2^width or more (carry out).
- R2: With `in_op`=1 (subtract) and `in_signed`=0, `out_cc[0]` is 1 exactly when the wrapped difference is nonzero, and `out_cc[1]` is 1 exactly when operand A is not less than operand B as unsigned values (no borrow).
- R3: With `in_signed`=1, `out_cc` is 3 whenever the true two's-complement sum or difference falls outside the range of the selected width.
- R4: With `in_signed`=1 and no overflow, `out_cc` is 0 for a zero result, 1 for a negative result and 2 for a positive result, with the sign taken at the top bit of the selected width.
- R5: `out_result` equals A+B (add) or A−B (subtract) modulo 2^width, for both values of `in_signed`.
- R6: With `in_wide`=0 (32-bit), bits 63:32 of both operands have no effect. `out_result[63:32]` is zero, and the condition code is computed from bits 31:0 only. `in_wide`=1 selects 64-bit operation.
- R7: `out_valid` is high in the cycle after each cycle with `in_valid` high and low otherwise. A synchronous active-low reset (`rst_n`=0) clears `out_valid`, `out_result` and `out_cc`.
- R8: While `in_valid` is low, `out_result` and `out_cc` hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe; the operands are sampled when it is high |
| in_op | input | 1 | 0 = add, 1 = subtract (A − B) |
| in_signed | input | 1 | 0 = logical/unsigned, 1 = arithmetic/signed |
| in_wide | input | 1 | 0 = 32-bit, 1 = 64-bit |
| in_a | input | 64 | Operand A |
| in_b | input | 64 | Operand B |
| out_valid | output | 1 | The result is valid (one cycle after a request) |
| out_result | output | 64 | Wrapped sum or difference |
| out_cc | output | 2 | Condition code |

## Verification
Logical add is tried with sums just below, exactly at and just above 2^width. This separates the carry flag from the nonzero flag, including the carry-with-zero-result case. Logical subtract is tried with A>B, A<B and A=B, which tells "no borrow" apart from "nonzero". Signed operations are tried at the most-positive and most-negative limits in both directions, including the case where min+min wraps to zero and must report overflow rather than zero. They are also tried with small mixed-sign values that yield each of zero, negative and positive. The same edges run in 32-bit mode with garbage in the upper operand halves and in 64-bit mode, and a pseudo-random sweep is compared against a wide-integer reference to catch any lane or sign-bit mix-up.

// File: rtl/fxadd_pkg.sv
// Package: shared encodings and flag bundle for the add/subtract unit.
// Assumes: the one-bit op/mode/width selects are decoded the same way everywhere.
package fxadd_pkg;

    // Operation select encoding
    localparam logic OP_ADD = 1'b0;
    localparam logic OP_SUB = 1'b1;

    // Condition codes used by the arithmetic (signed) family
    localparam logic [1:0] CC_ZERO = 2'd0;
    localparam logic [1:0] CC_NEG  = 2'd1;
    localparam logic [1:0] CC_POS  = 2'd2;
    localparam logic [1:0] CC_OVF  = 2'd3;

    // Status flags produced by one adder lane
    typedef struct packed {
        logic carry;  // carry out of the lane (no-borrow for subtract)
        logic zero;   // wrapped result is all zeros
        logic neg;    // top bit of the lane result
        logic ovf;    // two's-complement overflow
    } add_flags_t;

endpackage

// File: rtl/fxadd_core.sv
// Module: fxadd_core
// Combinational adder with two lanes, one per supported width, and a lane select.
// Subtraction is done as A + ~B + 1, so a lane's carry out is the no-borrow flag.
// Overflow is taken from sign bits: both addends share a sign and the result differs.
// Assumes: NARROW_W < DATA_W. The narrow lane looks only at the low NARROW_W bits.
module fxadd_core
    import fxadd_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 32
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              do_sub,
    input  logic              use_wide,
    output logic [DATA_W-1:0] sum_out,
    output add_flags_t        flags_out
);

    localparam int NUM_LANES = 2;

    logic [DATA_W-1:0] lane_sum   [NUM_LANES];
    add_flags_t        lane_flags [NUM_LANES];

    // Lane 0 is the narrow width and lane 1 is the full width
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        localparam int LW = (g == 0) ? NARROW_W : DATA_W;

        logic [LW-1:0] a_l;
        logic [LW-1:0] b_eff;
        logic [LW:0]   full;

        // Lane adder: invert B and inject carry-in for subtract
        always_comb begin
            a_l   = op_a[LW-1:0];
            b_eff = do_sub ? ~op_b[LW-1:0] : op_b[LW-1:0];
            full  = {1'b0, a_l} + {1'b0, b_eff} + {{LW{1'b0}}, do_sub};
        end

        // Lane flags from the carry and the sign bits
        always_comb begin
            lane_flags[g].carry = full[LW];
            lane_flags[g].zero  = (full[LW-1:0] == '0);
            lane_flags[g].neg   = full[LW-1];
            lane_flags[g].ovf   = (a_l[LW-1] == b_eff[LW-1]) && (full[LW-1] != a_l[LW-1]);
            lane_sum[g]         = DATA_W'(full[LW-1:0]);
        end
    end

    // Lane select by width mode
    always_comb begin
        sum_out   = use_wide ? lane_sum[1]   : lane_sum[0];
        flags_out = use_wide ? lane_flags[1] : lane_flags[0];
    end

endmodule

// File: rtl/fxadd_cc.sv
// Module: fxadd_cc
// Maps lane flags to the 2-bit condition code.
// Logical family: {carry/no-borrow, nonzero} as two independent bits.
// Arithmetic family: enumerated zero / negative / positive, with overflow taking priority.
// Assumes: the flags come from the lane that matches the selected width.
module fxadd_cc
    import fxadd_pkg::*;
(
    input  logic       signed_mode,
    input  add_flags_t flags,
    output logic [1:0] cc
);

    // Encode the condition code according to the family
    always_comb begin
        if (!signed_mode) begin
            cc = {flags.carry, ~flags.zero};
        end else if (flags.ovf) begin
            cc = CC_OVF;
        end else if (flags.zero) begin
            cc = CC_ZERO;
        end else if (flags.neg) begin
            cc = CC_NEG;
        end else begin
            cc = CC_POS;
        end
    end

    // R3/R4: a signed code never claims both zero and negative (immediate check)
    always_comb begin
        if (signed_mode && !flags.ovf && flags.zero) begin
            a_zero_not_neg_r4: assert (!flags.neg);
        end
    end

endmodule

// File: rtl/fxadd_unit.sv
// Module: fxadd_unit (top)
// Registered add/subtract unit with condition code. A request taken on in_valid
// produces out_result/out_cc with out_valid one clock later. Outputs hold between requests.
// Assumes: synchronous active-low reset. In 32-bit mode the result is zero-extended.
module fxadd_unit
    import fxadd_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int NARROW_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_op,
    input  logic              in_signed,
    input  logic              in_wide,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic [1:0]        out_cc
);

    localparam int UPPER_W = DATA_W - NARROW_W;

    logic [DATA_W-1:0] sum_c;
    add_flags_t        flags_c;
    logic [1:0]        cc_c;

    fxadd_core #(
        .DATA_W  (DATA_W),
        .NARROW_W(NARROW_W)
    ) u_core (
        .op_a     (in_a),
        .op_b     (in_b),
        .do_sub   (in_op == OP_SUB),
        .use_wide (in_wide),
        .sum_out  (sum_c),
        .flags_out(flags_c)
    );

    fxadd_cc u_cc (
        .signed_mode(in_signed),
        .flags      (flags_c),
        .cc         (cc_c)
    );

    // Valid strobe: follows the request by one clock
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Result registers: load on a request, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_result <= '0;
            out_cc     <= '0;
        end else if (in_valid) begin
            out_result <= sum_c;
            out_cc     <= cc_c;
        end
    end

    // R7: out_valid rises exactly one clock after a request
    p_valid_after_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R7: no output strobe without a request
    p_no_spurious_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R8: outputs hold while idle
    p_hold_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_result) && $stable(out_cc)));

    // R6: a narrow request leaves the upper result bits clear
    p_upper_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_wide) |=> (out_result[DATA_W-1 -: UPPER_W] == '0));

    // R1/R2: logical low bit means a nonzero result
    p_nonzero_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_signed) |=> (out_cc[0] == (out_result != '0)));

    // R4: signed negative code agrees with the stored result's sign (64-bit)
    p_neg_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_signed && in_wide) |=> ((out_cc == CC_NEG) -> out_result[DATA_W-1]));

    // R3/R4: a signed zero result reports zero or overflow only
    p_zero_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_signed) |=> ((out_result == '0) -> (out_cc == CC_ZERO || out_cc == CC_OVF)));

endmodule

// File: tb/fxadd_unit_bench.sv
module fxadd_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_op = 1'b0;
    logic        in_signed = 1'b0;
    logic        in_wide = 1'b0;
    logic [63:0] in_a = '0;
    logic [63:0] in_b = '0;
    logic        out_valid;
    logic [63:0] out_result;
    logic [1:0]  out_cc;

    int n_checks = 0;
    int n_fails  = 0;
    logic [63:0] lfsr = 64'h0123_4567_89AB_CDEF;

    always #10 clk = ~clk;  // 50 MHz

    fxadd_unit u_fxadd_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_signed(in_signed), .in_wide(in_wide), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_result(out_result), .out_cc(out_cc)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Reference model built from wide integer arithmetic
    task automatic model(input logic op, input logic sg, input logic wide,
                         input logic [63:0] a, input logic [63:0] b,
                         output logic [63:0] res, output logic [1:0] cc);
        int w;
        logic [63:0] mask, am, bm;
        logic signed [66:0] sa, sb, tru, wrapped;
        logic [66:0] ua, ub, usum;
        w    = wide ? 64 : 32;
        mask = wide ? '1 : 64'h0000_0000_FFFF_FFFF;
        am = a & mask; bm = b & mask;
        res = (op ? am - bm : am + bm) & mask;
        ua = {3'b0, am}; ub = {3'b0, bm};
        if (wide) begin
            sa = {{3{am[63]}}, am}; sb = {{3{bm[63]}}, bm};
            wrapped = {{3{res[63]}}, res};
        end else begin
            sa = {{35{am[31]}}, am[31:0]}; sb = {{35{bm[31]}}, bm[31:0]};
            wrapped = {{35{res[31]}}, res[31:0]};
        end
        if (!sg) begin
            usum = ua + ub;
            if (!op) cc = {(usum >> w) != 0, res != 0};
            else     cc = {ua >= ub, res != 0};
        end else begin
            tru = op ? sa - sb : sa + sb;
            if (tru != wrapped)  cc = 2'd3;
            else if (res == 0)   cc = 2'd0;
            else if (tru < 0)    cc = 2'd1;
            else                 cc = 2'd2;
        end
    endtask

    // Drive one request at a falling edge and check one clock later
    task automatic run_op(input string req, input logic op, input logic sg,
                          input logic wide, input logic [63:0] a, input logic [63:0] b);
        logic [63:0] er; logic [1:0] ec;
        model(op, sg, wide, a, b, er, ec);
        in_valid = 1'b1; in_op = op; in_signed = sg; in_wide = wide; in_a = a; in_b = b;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, "valid", {63'b0, out_valid}, 64'd1);
        check(req, "result", out_result, er);
        check(req, "cc", {62'b0, out_cc}, {62'b0, ec});
    endtask

    task automatic t_reset;
        // R7: reset state
        check("R7", "reset valid", {63'b0, out_valid}, 64'd0);
        check("R7", "reset result", out_result, 64'd0);
        check("R7", "reset cc", {62'b0, out_cc}, 64'd0);
    endtask

    task automatic t_logical_add;
        // R1, R5, R6: upper garbage in 32-bit mode
        run_op("R1", 0, 0, 0, 64'hDEAD_0000_0000_0001, 64'hBEEF_0000_0000_0001);
        run_op("R1", 0, 0, 0, 64'h0000_0000_FFFF_FFFF, 64'h1234_0000_0000_0001);
        run_op("R1", 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0002);
        run_op("R1", 0, 0, 0, 64'h0, 64'h0);
        run_op("R1", 0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);
        run_op("R5", 0, 0, 1, 64'h0000_0000_FFFF_FFFF, 64'h1);
    endtask

    task automatic t_logical_sub;
        run_op("R2", 1, 0, 0, 64'h5, 64'h3);
        run_op("R2", 1, 0, 0, 64'h3, 64'h5);
        run_op("R2", 1, 0, 0, 64'hAAAA_0000_0000_0005, 64'h5555_0000_0000_0005);
        run_op("R2", 1, 0, 1, 64'h0, 64'h0);
        run_op("R2", 1, 0, 1, 64'h1_0000_0000, 64'h1);
    endtask

    task automatic t_signed;
        run_op("R3", 0, 1, 0, 64'h7FFF_FFFF, 64'h1);
        run_op("R3", 0, 1, 0, 64'h8000_0000, 64'h8000_0000);
        run_op("R3", 1, 1, 0, 64'h8000_0000, 64'h1);
        run_op("R3", 1, 1, 0, 64'h7FFF_FFFF, 64'hFFFF_FFFF);
        run_op("R3", 1, 1, 0, 64'h0, 64'h8000_0000);
        run_op("R3", 0, 1, 1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1);
        run_op("R3", 1, 1, 1, 64'h8000_0000_0000_0000, 64'h1);
        run_op("R4", 0, 1, 0, 64'hFFFF_FFFF, 64'h1);
        run_op("R4", 0, 1, 0, 64'hFFFF_FFFB, 64'h2);
        run_op("R4", 0, 1, 0, 64'h2, 64'h3);
        run_op("R4", 1, 1, 0, 64'h1, 64'h2);
        run_op("R4", 1, 1, 1, 64'h3, 64'h3);
        run_op("R4", 0, 1, 1, 64'h0000_0000_7FFF_FFFF, 64'h1);
        run_op("R6", 0, 1, 0, 64'hFFFF_FFFF_0000_0001, 64'h0000_0001_0000_0001);
    endtask

    task automatic t_idle_hold;
        logic [63:0] r0; logic [1:0] c0;
        run_op("R8", 0, 0, 1, 64'h1234, 64'h4321);
        r0 = out_result; c0 = out_cc;
        in_a = 64'hFFFF; in_b = 64'hFFFF; in_op = 1'b1;
        @(negedge clk);
        check("R7", "idle valid", {63'b0, out_valid}, 64'd0);
        check("R8", "hold result", out_result, r0);
        check("R8", "hold cc", {62'b0, out_cc}, {62'b0, c0});
    endtask

    task automatic t_sweep;
        for (int i = 0; i < 400; i++) begin
            logic [63:0] a, b;
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 7); lfsr = lfsr ^ (lfsr << 17);
            a = lfsr;
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 7); lfsr = lfsr ^ (lfsr << 17);
            b = (i % 5 == 0) ? a : lfsr;
            run_op("R5", lfsr[0], lfsr[1], lfsr[2], a, b);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_logical_add();
        t_logical_sub();
        t_signed();
        t_idle_hold();
        t_sweep();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog: run did not complete");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule